// File: doc/BRIEF.md
# First-In/First-Out Buffer Controller with Read Rewind

This block is a single-device first-in/first-out buffer. It has its own storage array and the control around it: a write pointer and a read pointer, three status flags and a rewind control. All inputs are sampled on one system clock. A word is stored when the active-low write strobe is seen to fall. A word is fetched onto the registered output when the active-low read strobe is seen to fall. A strobe held low counts once; it must return high before it can count again.

The flags are active low and registered. They report empty, more than half occupied, and completely occupied. Writes are refused while the buffer is full and reads are refused while it is empty. A rewind input, also active low, returns the read pointer to storage location zero and leaves the write pointer alone, so data written since reset can be read again. Rewind is disabled when the block is strapped into chained (expansion) operation. A strobe driven low while a rewind is in effect is a protocol violation. It is recorded on a sticky error output that only reset clears.

Top module: `fifo_rt_ctrl`

## Requirements
- R1: A synchronous active-high `rst` returns both pointers to location zero, drives `empty_n` low, `full_n` and `half_n` high, `rd_data` to zero and `proto_err` low.
- R2: A write is accepted in the clock cycle where `wr_n` is sampled low after being sampled high in the previous cycle, provided `full_n` is high; accepted words go to consecutive locations regardless of read activity.
- R3: A read is accepted in the cycle where `rd_n` is sampled low after being sampled high, provided `empty_n` is high; `rd_data` then takes the oldest unread word at that clock edge and holds it until the next accepted read.
- R4: `empty_n` is low exactly when occupancy (written minus read) is zero.
- R5: `full_n` is low exactly when occupancy equals DEPTH; from reset with no reads it falls on the DEPTH-th accepted write.
- R6: A falling write strobe while full, and a falling read strobe while empty, change neither the stored data, the occupancy, the flags nor `rd_data`.
- R7: `half_n` is low exactly when occupancy is greater than DEPTH/2.
- R8: While `rt_n` is low and `expand_mode` is low, the read pointer is forced to location zero and the write pointer is left unchanged; the flags follow the resulting occupancy (write pointer minus zero).
- R9: While `expand_mode` is high, `rt_n` has no effect.
- R10: While a rewind is in effect, strobe falls are not accepted. Any low `wr_n` or `rd_n` sets `proto_err`, which stays high until reset.
- R11: A write and a read accepted in the same cycle both take effect and leave occupancy unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_n | input | 1 | Write strobe, active low, acts on its falling sample |
| rd_n | input | 1 | Read strobe, active low, acts on its falling sample |
| rt_n | input | 1 | Rewind read pointer to location zero, active low |
| expand_mode | input | 1 | High when chained; disables rewind |
| wr_data | input | WIDTH | Word to store |
| rd_data | output | WIDTH | Last word read, registered |
| empty_n | output | 1 | Low when occupancy is zero |
| full_n | output | 1 | Low when occupancy equals DEPTH |
| half_n | output | 1 | Low when occupancy exceeds DEPTH/2 |
| proto_err | output | 1 | Sticky: strobe active during rewind |

## Verification
The bench builds the block with DEPTH = 8 and WIDTH = 9. With that depth, filling to full, crossing the half-occupancy threshold in both directions and wrapping both pointers past the end of the array all take only a few dozen strobes. The nine-bit width lets the bench tell the top data bit apart from the rest. The table walk takes the buffer through full, back through half, past a pointer wrap, into empty and out again. The directed tests cover rewind after partial reads, rewind from empty that lands above half, rewind while chained, and the protocol error.

// File: rtl/fifo_rt_pkg.sv
package fifo_rt_pkg;

  // Registered status flags, all active low.
  typedef struct packed {
    logic empty_n;
    logic half_n;
    logic full_n;
  } flag_set_t;

  localparam flag_set_t FLAGS_AT_RESET = '{empty_n: 1'b0, half_n: 1'b1, full_n: 1'b1};

endpackage

// File: rtl/fifo_strobe_edge.sv
// Falling-edge detection for a group of active-low strobes.
module fifo_strobe_edge #(
  parameter int LANES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [LANES-1:0] strobe_n,
  output logic [LANES-1:0] fell,
  output logic [LANES-1:0] active
);

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic seen_n;

    always_ff @(posedge clk) begin
      if (rst) seen_n <= 1'b1;
      else     seen_n <= strobe_n[g];
    end

    assign fell[g]   = seen_n & ~strobe_n[g];
    assign active[g] = ~strobe_n[g];
  end

endmodule

// File: rtl/fifo_ptr_ctrl.sv
// Pointer, flag and protocol-error logic.
module fifo_ptr_ctrl
  import fifo_rt_pkg::*;
#(
  parameter int DEPTH = 512
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       wr_fell,
  input  logic                       rd_fell,
  input  logic                       wr_low,
  input  logic                       rd_low,
  input  logic                       rewind_req,
  input  logic                       expand_mode,
  output logic                       wr_go,
  output logic                       rd_go,
  output logic [$clog2(DEPTH)-1:0]   wr_addr,
  output logic [$clog2(DEPTH)-1:0]   rd_addr,
  output flag_set_t                  flags,
  output logic                       proto_err
);

  localparam int AW   = $clog2(DEPTH);
  localparam int PW   = AW + 1;
  localparam int HALF = DEPTH / 2;
  localparam logic [PW-1:0] FULL_OCC = PW'(DEPTH);
  localparam logic [PW-1:0] HALF_OCC = PW'(HALF);

  logic [PW-1:0] wptr, rptr, wptr_nx, rptr_nx, occ_nx;
  logic          rewind_on;
  flag_set_t     flags_nx;

  assign rewind_on = rewind_req & ~expand_mode;
  assign wr_go     = wr_fell & flags.full_n  & ~rewind_on;
  assign rd_go     = rd_fell & flags.empty_n & ~rewind_on;

  assign wptr_nx = wptr + PW'(wr_go);
  assign rptr_nx = rewind_on ? '0 : rptr + PW'(rd_go);
  assign occ_nx  = wptr_nx - rptr_nx;

  always_comb begin
    flags_nx.empty_n = (occ_nx != '0);
    flags_nx.full_n  = (occ_nx != FULL_OCC);
    flags_nx.half_n  = ~(occ_nx > HALF_OCC);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wptr  <= '0;
      rptr  <= '0;
      flags <= FLAGS_AT_RESET;
    end else begin
      wptr  <= wptr_nx;
      rptr  <= rptr_nx;
      flags <= flags_nx;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)                                proto_err <= 1'b0;
    else if (rewind_on & (wr_low | rd_low)) proto_err <= 1'b1;
  end

  assign wr_addr = wptr[AW-1:0];
  assign rd_addr = rptr[AW-1:0];

  // Write pointer frozen when a write strobe meets a full buffer.
  assert_no_overflow_R6: assert property (@(posedge clk) disable iff (rst)
    (!flags.full_n && wr_fell) |=> $stable(wptr));

  // Read pointer frozen when a read strobe meets an empty buffer.
  assert_no_underflow_R6: assert property (@(posedge clk) disable iff (rst)
    (!flags.empty_n && rd_fell && !rewind_on) |=> $stable(rptr));

  // Empty and full never at once.
  assert_empty_full_apart_R4: assert property (@(posedge clk) disable iff (rst)
    !(!flags.empty_n && !flags.full_n));

  // Full always implies above half.
  assert_full_above_half_R7: assert property (@(posedge clk) disable iff (rst)
    !flags.full_n |-> !flags.half_n);

  // Rewind lands read pointer at zero and leaves write pointer alone.
  assert_rewind_R8: assert property (@(posedge clk) disable iff (rst)
    rewind_on |=> (rptr == '0) && $stable(wptr));

  // Rewind ignored when chained.
  assert_chain_no_rewind_R9: assert property (@(posedge clk) disable iff (rst)
    (expand_mode && !rd_go) |=> $stable(rptr));

  // Error flag is sticky.
  assert_err_sticky_R10: assert property (@(posedge clk) disable iff (rst)
    proto_err |=> proto_err);

endmodule

// File: rtl/fifo_store.sv
// Storage array: one write port, one registered read port.
module fifo_store #(
  parameter int DEPTH = 512,
  parameter int WIDTH = 9
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     we,
  input  logic [$clog2(DEPTH)-1:0] waddr,
  input  logic [WIDTH-1:0]         wdata,
  input  logic                     re,
  input  logic [$clog2(DEPTH)-1:0] raddr,
  output logic [WIDTH-1:0]         rdata
);

  logic [WIDTH-1:0] cells [DEPTH];

  always_ff @(posedge clk) begin
    if (we) cells[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (rst)     rdata <= '0;
    else if (re) rdata <= cells[raddr];
  end

endmodule

// File: rtl/fifo_rt_ctrl.sv
module fifo_rt_ctrl
  import fifo_rt_pkg::*;
#(
  parameter int DEPTH = 512,
  parameter int WIDTH = 9
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_n,
  input  logic             rd_n,
  input  logic             rt_n,
  input  logic             expand_mode,
  input  logic [WIDTH-1:0] wr_data,
  output logic [WIDTH-1:0] rd_data,
  output logic             empty_n,
  output logic             full_n,
  output logic             half_n,
  output logic             proto_err
);

  localparam int AW = $clog2(DEPTH);

  logic [1:0]    fell, active;
  logic          wr_go, rd_go;
  logic [AW-1:0] wr_addr, rd_addr;
  flag_set_t     flags;

  fifo_strobe_edge #(.LANES(2)) u_edge (
    .clk      (clk),
    .rst      (rst),
    .strobe_n ({rd_n, wr_n}),
    .fell     (fell),
    .active   (active)
  );

  fifo_ptr_ctrl #(.DEPTH(DEPTH)) u_ptr (
    .clk         (clk),
    .rst         (rst),
    .wr_fell     (fell[0]),
    .rd_fell     (fell[1]),
    .wr_low      (active[0]),
    .rd_low      (active[1]),
    .rewind_req  (~rt_n),
    .expand_mode (expand_mode),
    .wr_go       (wr_go),
    .rd_go       (rd_go),
    .wr_addr     (wr_addr),
    .rd_addr     (rd_addr),
    .flags       (flags),
    .proto_err   (proto_err)
  );

  fifo_store #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_store (
    .clk   (clk),
    .rst   (rst),
    .we    (wr_go),
    .waddr (wr_addr),
    .wdata (wr_data),
    .re    (rd_go),
    .raddr (rd_addr),
    .rdata (rd_data)
  );

  assign empty_n = flags.empty_n;
  assign full_n  = flags.full_n;
  assign half_n  = flags.half_n;

  // Output data only moves on an accepted read (R3).
  assert_rdata_hold_R3: assert property (@(posedge clk) disable iff (rst)
    !rd_go |=> $stable(rd_data));

endmodule

// File: tb/tb_fifo_rt_ctrl.sv
`timescale 1ns/1ps
module tb_fifo_rt_ctrl;

  localparam int DEPTH = 8;
  localparam int WIDTH = 9;
  localparam int NVEC  = 22;

  // {op[1:0], din[8:0], flags{empty_n,half_n,full_n}[2:0], q[8:0]}
  // op: 0 write, 1 read, 2 write+read
  localparam logic [22:0] VEC [NVEC] = '{
    {2'd0, 9'h101, 3'b111, 9'h000},
    {2'd0, 9'h0A2, 3'b111, 9'h000},
    {2'd0, 9'h053, 3'b111, 9'h000},
    {2'd0, 9'h1F4, 3'b111, 9'h000},
    {2'd0, 9'h005, 3'b101, 9'h000},
    {2'd0, 9'h136, 3'b101, 9'h000},
    {2'd0, 9'h0C7, 3'b101, 9'h000},
    {2'd0, 9'h188, 3'b100, 9'h000},
    {2'd0, 9'h0FF, 3'b100, 9'h000},
    {2'd1, 9'h000, 3'b101, 9'h101},
    {2'd1, 9'h000, 3'b101, 9'h0A2},
    {2'd1, 9'h000, 3'b101, 9'h053},
    {2'd1, 9'h000, 3'b111, 9'h1F4},
    {2'd2, 9'h0AA, 3'b111, 9'h005},
    {2'd1, 9'h000, 3'b111, 9'h136},
    {2'd1, 9'h000, 3'b111, 9'h0C7},
    {2'd1, 9'h000, 3'b111, 9'h188},
    {2'd1, 9'h000, 3'b011, 9'h0AA},
    {2'd1, 9'h000, 3'b011, 9'h0AA},
    {2'd0, 9'h011, 3'b111, 9'h0AA},
    {2'd2, 9'h022, 3'b111, 9'h011},
    {2'd1, 9'h000, 3'b011, 9'h022}
  };

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             wr_n = 1'b1, rd_n = 1'b1, rt_n = 1'b1, expand_mode = 1'b0;
  logic [WIDTH-1:0] wr_data = '0;
  logic [WIDTH-1:0] rd_data;
  logic             empty_n, full_n, half_n, proto_err;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  fifo_rt_ctrl #(.DEPTH(DEPTH), .WIDTH(WIDTH)) dut (
    .clk(clk), .rst(rst), .wr_n(wr_n), .rd_n(rd_n), .rt_n(rt_n),
    .expand_mode(expand_mode), .wr_data(wr_data), .rd_data(rd_data),
    .empty_n(empty_n), .full_n(full_n), .half_n(half_n), .proto_err(proto_err)
  );

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1'b1;
    @(negedge clk); @(negedge clk); rst = 1'b0;
    @(negedge clk);
  endtask

  // op 0 write, 1 read, 2 both
  task automatic strobe(input int op, input logic [WIDTH-1:0] d);
    @(negedge clk);
    wr_data = d;
    if (op != 1) wr_n = 1'b0;
    if (op != 0) rd_n = 1'b0;
    @(negedge clk);
    wr_n = 1'b1; rd_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic rewind_pulse();
    @(negedge clk); rt_n = 1'b0;
    @(negedge clk); rt_n = 1'b1;
    @(negedge clk);
  endtask

  function automatic logic [15:0] flg();
    return {13'd0, empty_n, half_n, full_n};
  endfunction

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL R1 watchdog: actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    do_reset();
    // R1 reset state
    check("R1 flags after reset", flg(), 16'b011);
    check("R1 rd_data after reset", 16'(rd_data), 16'h000);
    check("R1 proto_err after reset", 16'(proto_err), 16'h0);

    // Table walk: fill, overfill, drain through half, wrap, empty, underflow.
    for (int i = 0; i < NVEC; i++) begin
      logic [1:0] op;
      logic [8:0] din, q;
      logic [2:0] ef;
      string tag;
      {op, din, ef, q} = VEC[i];
      strobe(int'(op), din);
      if (i == 8 || i == 18) tag = "R6 ignored strobe";
      else if (op == 2'd2)   tag = "R11 write+read";
      else if (op == 2'd1)   tag = "R3 read order";
      else                   tag = "R2 write";
      check($sformatf("%s flags R4 R5 R7 vec %0d", tag, i), flg(), 16'(ef));
      check($sformatf("%s data vec %0d", tag, i), 16'(rd_data), 16'(q));
    end

    // R8: rewind after partial reads
    do_reset();
    strobe(0, 9'h031); strobe(0, 9'h032); strobe(0, 9'h033);
    strobe(1, 0); strobe(1, 0);
    check("R3 data before rewind", 16'(rd_data), 16'h032);
    rewind_pulse();
    check("R8 flags after rewind", flg(), 16'b111);
    strobe(1, 0);
    check("R8 first word again", 16'(rd_data), 16'h031);
    strobe(0, 9'h034);
    strobe(1, 0);
    check("R8 second word", 16'(rd_data), 16'h032);
    strobe(1, 0);
    check("R8 third word", 16'(rd_data), 16'h033);
    strobe(1, 0);
    check("R8 write ptr kept", 16'(rd_data), 16'h034);
    check("R8 empty after drain", flg(), 16'b011);

    // R8 / R7: rewind from empty back above half
    do_reset();
    for (int k = 0; k < 6; k++) strobe(0, 9'(k + 16'h150));
    for (int k = 0; k < 6; k++) strobe(1, 0);
    check("R4 empty after six reads", flg(), 16'b011);
    rewind_pulse();
    check("R8 R7 rewind lands above half", flg(), 16'b101);
    strobe(1, 0);
    check("R8 data after rewind", 16'(rd_data), 16'h150);

    // R9: chained mode disables rewind
    for (int k = 0; k < 5; k++) strobe(1, 0);
    check("R9 empty before chained rewind", flg(), 16'b011);
    expand_mode = 1'b1;
    rewind_pulse();
    check("R9 rewind ignored when chained", flg(), 16'b011);
    check("R9 no error when chained", 16'(proto_err), 16'h0);
    expand_mode = 1'b0;

    // R10: strobe during rewind
    do_reset();
    strobe(0, 9'h041); strobe(0, 9'h042);
    @(negedge clk); rt_n = 1'b0;
    @(negedge clk); wr_n = 1'b0; wr_data = 9'h1FF;
    @(negedge clk); wr_n = 1'b1;
    @(negedge clk); rt_n = 1'b1;
    @(negedge clk);
    check("R10 error raised", 16'(proto_err), 16'h1);
    strobe(1, 0); strobe(1, 0);
    check("R10 write during rewind dropped data", 16'(rd_data), 16'h042);
    check("R10 write during rewind dropped count", flg(), 16'b011);
    check("R10 error sticky", 16'(proto_err), 16'h1);
    do_reset();
    check("R1 reset clears error", 16'(proto_err), 16'h0);
    check("R1 reset clears data", 16'(rd_data), 16'h000);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule